// File: doc/BRIEF.md
# Stochastic Floating-Point Mantissa Rounder

This block takes a floating-point magnitude whose mantissa still carries extra low-order bits from an arithmetic stage. It rounds that mantissa down to the target width. A 3-bit mode selects one of five deterministic rounding directions, or a stochastic mode. In stochastic mode the block picks between the truncated value and the next representable value. The choice is made by comparing a pseudo-random number with the discarded bits, so over many operations the mean result tracks the exact input value.

The random number comes from an internal linear feedback shift register. The register is loaded from a seed port on reset and steps once for each valid input. An optional static bit-permutation stage reshuffles its bits before they are used. The path from inputs to outputs is combinational, and the only state is the random-source register.

Parameters set the target mantissa width, the number of extra bits, the width of the stochastic comparison window, the register length and the permutation stage. This lets one design serve formats from double precision down to 8-bit formats. Exponent range, infinities, subnormals and NaNs are handled elsewhere.

Top module: `sr_round_unit`

## Requirements
- R1: Mode code 000 rounds to nearest with ties to even: the result goes up when the top discarded bit is 1 and either some lower discarded bit or the sticky input is 1, or the kept LSB is 1.
- R2: Mode code 001 truncates. The kept bits pass through unchanged and the exponent-increment output stays low.
- R3: Mode code 010 rounds up only a negative inexact value (sign 1). Mode code 011 rounds up only a positive inexact value (sign 0).
- R4: Mode code 100 rounds to nearest with ties away from zero: the result goes up whenever the top discarded bit is 1.
- R5: Mode codes 110 and 111 behave exactly as code 000.
- R6: In stochastic mode (code 101) the result is always either the truncated mantissa or that value plus one unit in the last place.
- R7: In stochastic mode the result goes up when the random value is strictly less than the top SR_W discarded bits. The rate of rounding up therefore follows the discarded fraction: about half for a half-unit fraction, and nearly always for an all-ones window.
- R8: In stochastic mode, discarded bits below the SR_W-bit window and the sticky input have no effect on the rounding direction.
- R9: The inexact output is 1 exactly when any discarded bit or the sticky input is 1. An exact input passes unchanged in every mode.
- R10: When rounding up carries out of the mantissa, the result becomes the leading-one pattern (MSB 1, all else 0) and the exponent-increment output is 1.
- R11: The random register loads the seed on a synchronous reset, or a fixed non-zero value if the seed is zero. It steps once per clock with in_valid high, holds otherwise, and is never all-zero. The same seed and the same valid pattern give the same stochastic decisions.
- R12: The outputs follow the inputs combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the random source |
| rst | input | 1 | Synchronous active-high reset, loads the seed |
| in_valid | input | 1 | Input accepted this cycle; steps the random source |
| in_sign | input | 1 | Sign of the value being rounded |
| in_mant | input | MAN_W+EXT_W | Mantissa: kept bits on top, discarded bits below |
| in_sticky | input | 1 | OR of bits lost before this stage |
| rmode | input | 3 | Rounding mode code |
| seed | input | LFSR_W | Seed for the random source |
| out_mant | output | MAN_W | Rounded mantissa |
| exp_inc | output | 1 | Carry out of the mantissa; exponent must increment |
| inexact | output | 1 | Some discarded information was non-zero |

## Verification
The bench targets exact ties in both nearest modes, with and without sticky. A wrong tie-break shows up as an odd result or a tie that fails to move away from zero. It sweeps the two directed modes over both signs, which catches a design that ignores the sign and rounds the wrong way. It also drives an all-ones mantissa up to catch a dropped carry or a missing exponent increment. In stochastic mode it counts round-ups over long runs for empty, half, full and below-window fractions. A fixed random value, a stuck all-zero register, or a comparison that includes the low bits would each push a count out of its band. Finally it replays a sequence after reset with idle cycles inserted, which exposes a register that steps without valid input.

// File: rtl/sr_round_pkg.sv
package sr_round_pkg;

  typedef enum logic [2:0] {
    RM_NE = 3'b000,
    RM_TZ = 3'b001,
    RM_DN = 3'b010,
    RM_UP = 3'b011,
    RM_MM = 3'b100,
    RM_SR = 3'b101
  } rmode_e;

  // Feedback mask for a shift register of width w; bit w-1 is always set
  // so the update is invertible and a non-zero state stays non-zero.
  function automatic logic [63:0] lfsr_mask(input int w);
    case (w)
      8:       return 64'h0000_0000_0000_00B8;
      16:      return 64'h0000_0000_0000_D008;
      24:      return 64'h0000_0000_00E1_0000;
      32:      return 64'h0000_0000_8020_0003;
      default: return 64'd3 << (w - 2);
    endcase
  endfunction

  // Stride for the bit permutation; must be coprime with w.
  function automatic int perm_stride(input int w);
    if ((w % 5) != 0) return 5;
    else if ((w % 7) != 0) return 7;
    else return 1;
  endfunction

endpackage

// File: rtl/sr_lfsr.sv
module sr_lfsr #(
  parameter int W        = 16,
  parameter int OUT_W    = 12,
  parameter bit SCRAMBLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [W-1:0]     seed,
  output logic [OUT_W-1:0] rnd
);
  import sr_round_pkg::*;

  localparam logic [63:0] MASK64 = lfsr_mask(W);
  localparam logic [W-1:0] MASK  = MASK64[W-1:0];
  localparam int STRIDE          = perm_stride(W);
  localparam logic [W-1:0] ALT_SEED = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] state;
  logic [W-1:0] state_nxt;

  assign state_nxt = {state[W-2:0], ^(state & MASK)};

  always_ff @(posedge clk) begin
    if (rst) state <= (seed == '0) ? ALT_SEED : seed;
    else if (step) state <= state_nxt;
  end

  generate
    if (SCRAMBLE) begin : g_perm
      for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        assign rnd[i] = state[(i * STRIDE + 1) % W];
      end
    end else begin : g_direct
      assign rnd = state[OUT_W-1:0];
    end
  endgenerate

  // R11
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);
  // R11
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));
  // R11
  lfsr_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> state != $past(state));

endmodule

// File: rtl/sr_round_decide.sv
module sr_round_decide #(
  parameter int EXT_W = 14,
  parameter int SR_W  = 12
) (
  input  logic             sign,
  input  logic [2:0]       mode,
  input  logic             keep_lsb,
  input  logic [EXT_W-1:0] disc,
  input  logic             sticky,
  input  logic [SR_W-1:0]  rnd,
  output logic             up,
  output logic             inexact
);
  import sr_round_pkg::*;

  logic            guard_bit;
  logic            rest_bits;
  logic [SR_W-1:0] window;

  assign guard_bit = disc[EXT_W-1];
  assign rest_bits = (|disc[EXT_W-2:0]) | sticky;
  assign window    = disc[EXT_W-1 -: SR_W];
  assign inexact   = guard_bit | rest_bits;

  always_comb begin
    case (rmode_e'(mode))
      RM_TZ:   up = 1'b0;
      RM_DN:   up = sign & inexact;
      RM_UP:   up = ~sign & inexact;
      RM_MM:   up = guard_bit;
      RM_SR:   up = (rnd < window);
      default: up = guard_bit & (rest_bits | keep_lsb);
    endcase
  end

endmodule

// File: rtl/sr_round_unit.sv
module sr_round_unit #(
  parameter int MAN_W    = 11,
  parameter int EXT_W    = 14,
  parameter int SR_W     = 12,
  parameter int LFSR_W   = 16,
  parameter bit SCRAMBLE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_sign,
  input  logic [MAN_W+EXT_W-1:0] in_mant,
  input  logic                   in_sticky,
  input  logic [2:0]             rmode,
  input  logic [LFSR_W-1:0]      seed,
  output logic [MAN_W-1:0]       out_mant,
  output logic                   exp_inc,
  output logic                   inexact
);
  localparam int IN_W = MAN_W + EXT_W;
  localparam logic [MAN_W-1:0] LEAD = {1'b1, {(MAN_W-1){1'b0}}};

  generate
    if (SR_W > EXT_W || SR_W > LFSR_W || EXT_W < 2 || MAN_W < 2) begin : g_bad_cfg
      $error("sr_round_unit: illegal width combination");
    end
  endgenerate

  logic [MAN_W-1:0] keep;
  logic [EXT_W-1:0] disc;
  logic [SR_W-1:0]  rnd;
  logic             up;
  logic [MAN_W:0]   sum;

  assign keep = in_mant[IN_W-1:EXT_W];
  assign disc = in_mant[EXT_W-1:0];

  sr_lfsr #(
    .W(LFSR_W), .OUT_W(SR_W), .SCRAMBLE(SCRAMBLE)
  ) u_rng (
    .clk(clk), .rst(rst), .step(in_valid), .seed(seed), .rnd(rnd)
  );

  sr_round_decide #(
    .EXT_W(EXT_W), .SR_W(SR_W)
  ) u_dec (
    .sign(in_sign), .mode(rmode), .keep_lsb(keep[0]), .disc(disc),
    .sticky(in_sticky), .rnd(rnd), .up(up), .inexact(inexact)
  );

  assign sum      = {1'b0, keep} + {{MAN_W{1'b0}}, up};
  assign exp_inc  = sum[MAN_W];
  assign out_mant = sum[MAN_W] ? LEAD : sum[MAN_W-1:0];

  // R9
  exact_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !inexact) |-> (out_mant == keep && !exp_inc));
  // R10
  carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    exp_inc |-> (out_mant == LEAD && keep == {MAN_W{1'b1}}));
  // R6
  sr_candidate_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rmode == 3'b101) |->
      (out_mant == keep || out_mant == keep + 1'b1 || exp_inc));
  // R2
  trunc_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rmode == 3'b001) |-> (out_mant == keep && !exp_inc));

endmodule

// File: tb/sr_round_unit_test.sv
module sr_round_unit_test;
  localparam int MAN_W = 11, EXT_W = 14, SR_W = 12, LFSR_W = 16;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_sign = 1'b0, in_sticky = 1'b0;
  logic [MAN_W+EXT_W-1:0] in_mant = '0;
  logic [2:0] rmode = 3'b000;
  logic [LFSR_W-1:0] seed = 16'hACE1;
  logic [MAN_W-1:0] out_mant;
  logic exp_inc, inexact;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sr_round_unit #(.MAN_W(MAN_W), .EXT_W(EXT_W), .SR_W(SR_W), .LFSR_W(LFSR_W), .SCRAMBLE(1'b1))
  uut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign), .in_mant(in_mant),
       .in_sticky(in_sticky), .rmode(rmode), .seed(seed), .out_mant(out_mant),
       .exp_inc(exp_inc), .inexact(inexact));

  task automatic chk(input string req, input bit ok, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic do_reset(input logic [LFSR_W-1:0] s);
    @(negedge clk); rst = 1'b1; seed = s; in_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic drive(input bit v, input bit sg, input logic [MAN_W-1:0] k,
                       input logic [EXT_W-1:0] d, input bit st, input logic [2:0] m);
    in_valid = v; in_sign = sg; in_mant = {k, d}; in_sticky = st; rmode = m;
  endtask

  // Expected up decision for deterministic modes, from R1-style rules
  function automatic bit ref_up(input bit sg, input logic [MAN_W-1:0] k,
                                input logic [EXT_W-1:0] d, input bit st, input logic [2:0] m);
    bit g, r, ix;
    g = d[EXT_W-1]; r = (d[EXT_W-2:0] != 0) || st; ix = g || r;
    case (m)
      3'b001: return 1'b0;
      3'b010: return sg && ix;
      3'b011: return !sg && ix;
      3'b100: return g;
      default: return g && (r || k[0]);
    endcase
  endfunction

  task automatic det_case(input string req, input bit sg, input logic [MAN_W-1:0] k,
                          input logic [EXT_W-1:0] d, input bit st, input logic [2:0] m);
    logic [MAN_W:0] s;
    logic [MAN_W-1:0] e_m;
    bit e_ix;
    s = {1'b0, k} + {{MAN_W{1'b0}}, ref_up(sg, k, d, st, m)};
    e_m = s[MAN_W] ? {1'b1, {(MAN_W-1){1'b0}}} : s[MAN_W-1:0];
    e_ix = (d != 0) || st;
    @(negedge clk); drive(1'b1, sg, k, d, st, m);
    #2;
    chk(req, out_mant == e_m, int'(out_mant), int'(e_m));
    chk(req, exp_inc == s[MAN_W], int'(exp_inc), int'(s[MAN_W]));
    chk("R9", inexact == e_ix, int'(inexact), int'(e_ix));
  endtask

  task automatic test_reset_state;
    do_reset(16'hACE1);
    @(negedge clk); drive(1'b0, 1'b0, '0, '0, 1'b0, 3'b000); #2;
    chk("R12 reset", out_mant == 0 && !exp_inc && !inexact,
        int'({out_mant, exp_inc, inexact}), 0);
  endtask

  task automatic test_nearest;
    det_case("R1 tie even stays", 0, 11'h400, 14'h2000, 0, 3'b000);
    det_case("R1 tie odd up", 0, 11'h401, 14'h2000, 0, 3'b000);
    det_case("R1 above half", 0, 11'h400, 14'h2001, 0, 3'b000);
    det_case("R1 sticky breaks tie", 0, 11'h400, 14'h2000, 1, 3'b000);
    det_case("R1 below half", 1, 11'h4FF, 14'h1FFF, 1, 3'b000);
    det_case("R4 tie away", 0, 11'h400, 14'h2000, 0, 3'b100);
    det_case("R4 below half", 0, 11'h400, 14'h1FFF, 1, 3'b100);
  endtask

  task automatic test_directed;
    det_case("R2 truncate", 0, 11'h400, 14'h3FFF, 1, 3'b001);
    det_case("R3 dn pos", 0, 11'h455, 14'h0001, 0, 3'b010);
    det_case("R3 dn neg", 1, 11'h455, 14'h0001, 0, 3'b010);
    det_case("R3 up pos", 0, 11'h455, 14'h0000, 1, 3'b011);
    det_case("R3 up neg", 1, 11'h455, 14'h3000, 0, 3'b011);
    det_case("R5 code 110", 0, 11'h401, 14'h2000, 0, 3'b110);
    det_case("R5 code 111", 0, 11'h402, 14'h2000, 0, 3'b111);
  endtask

  task automatic test_carry_and_exact;
    det_case("R10 carry up", 0, 11'h7FF, 14'h0001, 0, 3'b011);
    det_case("R10 carry nearest", 1, 11'h7FF, 14'h2001, 0, 3'b000);
    for (int m = 0; m < 8; m++)
      det_case("R9 exact", m[0], 11'h5A5, 14'h0000, 0, m[2:0]);
    @(negedge clk); drive(1'b1, 0, 11'h5A5, 14'h0000, 0, 3'b101); #2;
    chk("R9 exact stochastic", out_mant == 11'h5A5 && !inexact && !exp_inc,
        int'(out_mant), 32'h5A5);
  endtask

  task automatic sr_run(input logic [EXT_W-1:0] d, input bit st, input int n, output int ups);
    ups = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); drive(1'b1, i[0], 11'h300, d, st, 3'b101); #2;
      chk("R6 candidate", out_mant == 11'h300 || out_mant == 11'h301,
          int'(out_mant), 32'h300);
      if (out_mant == 11'h301) ups++;
    end
  endtask

  task automatic test_stochastic;
    int u;
    do_reset(16'hACE1);
    sr_run(14'h2000, 0, 1000, u);
    chk("R7 half fraction rate", u >= 350 && u <= 650, u, 500);
    sr_run(14'h1000, 0, 1000, u);
    chk("R7 quarter fraction rate", u >= 120 && u <= 380, u, 250);
    sr_run(14'h3FFC, 0, 500, u);
    chk("R7 full window rate", u >= 490, u, 500);
    sr_run(14'h0003, 1, 300, u);
    chk("R8 below window ignored", u == 0, u, 0);
    @(negedge clk); drive(1'b1, 0, 11'h300, 14'h0003, 0, 3'b101); #2;
    chk("R8 inexact still set", inexact == 1'b1, int'(inexact), 1);
    do_reset(16'h0000);
    sr_run(14'h2000, 0, 600, u);
    chk("R11 zero seed not stuck", u >= 180 && u <= 420, u, 300);
  endtask

  task automatic test_replay;
    bit rec [40];
    logic [MAN_W-1:0] a, b;
    do_reset(16'h1234);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); drive(1'b1, 0, 11'h300, 14'h2000, 0, 3'b101); #2;
      rec[i] = (out_mant == 11'h301);
    end
    do_reset(16'h1234);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); drive(1'b0, 0, 11'h300, 14'h2000, 0, 3'b101); #2; a = out_mant;
      @(negedge clk); #2; b = out_mant;
      chk("R11 hold when idle", a == b, int'(b), int'(a));
      @(negedge clk); in_valid = 1'b1; #2;
      chk("R11 replay", (out_mant == 11'h301) == rec[i], int'(out_mant == 11'h301), int'(rec[i]));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    test_reset_state();
    test_nearest();
    test_directed();
    test_carry_and_exact();
    test_stochastic();
    test_replay();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule